// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device-side engine that works through a ring of transmit descriptors held in host memory. Software supplies the ring's base address, its size in bytes and a tail index, and can load the head index. Whenever the engine is enabled and head differs from tail, it owns the descriptors from head up to, but not including, tail. It processes them one at a time through a single 64-bit memory request port.

For each descriptor the engine reads two 64-bit words. It then streams the referenced buffer one byte per cycle to a byte output, starting at any byte alignment. The last byte of a packet is flagged. If the descriptor asks for it, the engine writes the descriptor's second word back with the done bit set in its status byte. It then advances head and pulses event outputs for an interrupt block: one for a status write-back and one for reaching the tail. A packet may span several consecutive descriptors. Only the final one carries the end-of-packet command bit.

Top module: `txr_engine`

## Requirements
- R1: After reset, head is 0 and no outputs are active. While head equals tail, or while bit 1 of `tx_ctl` is clear, the engine issues no memory request.
- R2: Descriptor n sits at `ring_base + 16*n`. The engine reads the word at offset 0 first; bits 31:0 of that word are the buffer address. It then reads the word at offset 8, where bits 15:0 are the length, bits 31:24 the command byte and bits 39:32 the status byte. A request holds its address and direction until `mem_ack`.
- R3: The buffer's `length` bytes come out on `out_data` in ascending address order, one per `out_valid` cycle, from any starting byte alignment. Within a 64-bit word, byte k is data bits 8k+7:8k.
- R4: `out_last` is high only on the final byte of a descriptor whose command bit 0 (end of packet) is set.
- R5: When command bit 3 (report status) is set, the engine writes the second descriptor word back with status bit 0 (done) set and every other field unchanged. Without bit 3, it writes nothing back.
- R6: `ev_wb` pulses for one cycle two cycles after the acknowledged status write.
- R7: After each descriptor, head advances by one. It wraps to 0 when it reaches `ring_bytes/16`.
- R8: `ev_qe` pulses for one cycle when an advance makes head equal to tail.
- R9: Clearing `tx_ctl` bit 1 lets the descriptor in progress finish, including its output bytes and head advance. No further descriptor starts until the bit is set again.
- R10: A descriptor whose length is zero produces no output bytes. It is still written back if it requests status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_bytes | input | IDX_W+5 | Ring size in bytes (descriptor count times 16) |
| tail_idx | input | IDX_W | Software tail index |
| tx_ctl | input | 8 | Control; bit 1 enables transmission |
| head_load | input | 1 | Load head from `head_wdata` |
| head_wdata | input | IDX_W | Value for a head load |
| head_idx | output | IDX_W | Current head index |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | 8-byte aligned word address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completion |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a packet |
| ev_wb | output | 1 | Status write-back event pulse |
| ev_qe | output | 1 | Queue-empty event pulse |

## Verification
The hardest condition to reach from the ports is a disable that arrives while a descriptor is still streaming. The bench programs two 20-byte descriptors and enables the engine. It waits for the first output byte and clears the enable bit in the next cycle. It then checks that exactly one descriptor's bytes appeared and that head stopped one step further on. Head wrap-around is reached by running a two-descriptor packet that starts at the last ring slot. Word-straddling buffers start at odd addresses, so one descriptor crosses a 64-bit boundary.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
  localparam int WORD_BYTES = 8;
  localparam int DESC_BYTES = 16;
  // field positions inside the second descriptor word
  localparam int LEN_LSB = 0;
  localparam int LEN_W   = 16;
  localparam int CMD_LSB = 24;
  localparam int STS_LSB = 32;
  // command bits
  localparam int CMD_EOP  = 0;
  localparam int CMD_IFCS = 1;
  localparam int CMD_RS   = 3;
  localparam int CMD_EXT  = 5;
  localparam int CMD_IDE  = 7;
  // status bits
  localparam int STS_DD = 0;
  // control bits
  localparam int CTL_EN = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_A, S_FETCH_B, S_BUF_RD, S_EMIT, S_STATUS_WR, S_ADVANCE
  } txr_state_e;
endpackage

// File: rtl/txr_head_ptr.sv
`timescale 1ns/1ps
module txr_head_ptr #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             adv,
  input  logic [IDX_W:0]   ring_cnt,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] head_after
);
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W:0]   inc;
  logic             head_en;

  always_comb begin
    inc        = {1'b0, head_q} + 1'b1;
    head_after = (inc >= ring_cnt) ? '0 : inc[IDX_W-1:0];
    head_en    = load | adv;
    head_d     = load ? load_val : head_after;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       head_q <= '0;
    else if (head_en) head_q <= head_d;
  end

  assign head = head_q;

  // advance moves one slot forward or wraps to zero
  assert_head_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (head_q == '0 || head_q == $past(head_q) + 1'b1));
endmodule

// File: rtl/txr_byte_lane.sv
`timescale 1ns/1ps
module txr_byte_lane #(
  parameter int WORD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [8*WORD_BYTES-1:0]       word_in,
  input  logic [$clog2(WORD_BYTES)-1:0] sel,
  output logic [7:0]                    byte_out
);
  logic [8*WORD_BYTES-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  assign byte_out = word_q[8*sel +: 8];
endmodule

// File: rtl/txr_engine.sv
`timescale 1ns/1ps
module txr_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDX_W+4:0]  ring_bytes,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic [7:0]        tx_ctl,
  input  logic              head_load,
  input  logic [IDX_W-1:0]  head_wdata,
  output logic [IDX_W-1:0]  head_idx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              ev_wb,
  output logic              ev_qe
);
  localparam int SEL_W = $clog2(WORD_BYTES);

  txr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] buf_addr_q, buf_addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [63:0]       w1_q;
  logic              w1_en, lane_load, adv;
  logic              ev_wb_d, ev_qe_d, ev_wb_q, ev_qe_q;
  logic [IDX_W-1:0]  head_after;
  logic [ADDR_W-1:0] desc_addr;
  logic              rs_bit, eop_bit;

  txr_head_ptr #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .load(head_load), .load_val(head_wdata),
    .adv(adv), .ring_cnt(ring_bytes[IDX_W+4:4]),
    .head(head_idx), .head_after(head_after));

  txr_byte_lane #(.WORD_BYTES(WORD_BYTES)) u_lane (
    .clk(clk), .rst_n(rst_n), .load(lane_load), .word_in(mem_rdata),
    .sel(buf_addr_q[SEL_W-1:0]), .byte_out(out_data));

  assign desc_addr = ring_base + ADDR_W'({head_idx, 4'b0000});
  assign rs_bit    = w1_q[CMD_LSB+CMD_RS];
  assign eop_bit   = w1_q[CMD_LSB+CMD_EOP];

  // memory port and byte output decode
  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = desc_addr;
    unique case (state_q)
      S_FETCH_A:   mem_req = 1'b1;
      S_FETCH_B:   begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(WORD_BYTES); end
      S_BUF_RD:    begin mem_req = 1'b1; mem_addr = {buf_addr_q[ADDR_W-1:SEL_W], {SEL_W{1'b0}}}; end
      S_STATUS_WR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_addr + ADDR_W'(WORD_BYTES); end
      default: ;
    endcase
  end

  assign mem_wdata = w1_q | (64'd1 << (STS_LSB + STS_DD));
  assign out_valid = (state_q == S_EMIT);
  assign out_last  = out_valid && (remain_q == LEN_W'(1)) && eop_bit;
  assign ev_wb     = ev_wb_q;
  assign ev_qe     = ev_qe_q;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    buf_addr_d = buf_addr_q;
    remain_d   = remain_q;
    w1_en      = 1'b0;
    lane_load  = 1'b0;
    adv        = 1'b0;
    ev_wb_d    = 1'b0;
    ev_qe_d    = 1'b0;
    unique case (state_q)
      S_IDLE:
        if (tx_ctl[CTL_EN] && head_idx != tail_idx) state_d = S_FETCH_A;
      S_FETCH_A:
        if (mem_ack) begin
          buf_addr_d = mem_rdata[ADDR_W-1:0];
          state_d    = S_FETCH_B;
        end
      S_FETCH_B:
        if (mem_ack) begin
          w1_en    = 1'b1;
          remain_d = mem_rdata[LEN_LSB +: LEN_W];
          if (mem_rdata[LEN_LSB +: LEN_W] == '0)
            state_d = mem_rdata[CMD_LSB+CMD_RS] ? S_STATUS_WR : S_ADVANCE;
          else
            state_d = S_BUF_RD;
        end
      S_BUF_RD:
        if (mem_ack) begin
          lane_load = 1'b1;
          state_d   = S_EMIT;
        end
      S_EMIT: begin
        buf_addr_d = buf_addr_q + 1'b1;
        remain_d   = remain_q - 1'b1;
        if (remain_q == LEN_W'(1))           state_d = rs_bit ? S_STATUS_WR : S_ADVANCE;
        else if (&buf_addr_q[SEL_W-1:0])     state_d = S_BUF_RD;
      end
      S_STATUS_WR:
        if (mem_ack) state_d = S_ADVANCE;
      S_ADVANCE: begin
        adv     = 1'b1;
        ev_wb_d = rs_bit;
        ev_qe_d = (head_after == tail_idx);
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      buf_addr_q <= '0;
      remain_q   <= '0;
      ev_wb_q    <= 1'b0;
      ev_qe_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      buf_addr_q <= buf_addr_d;
      remain_q   <= remain_d;
      ev_wb_q    <= ev_wb_d;
      ev_qe_q    <= ev_qe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     w1_q <= '0;
    else if (w1_en) w1_q <= mem_rdata;
  end

  logic unused_bits;
  assign unused_bits = ^{ring_bytes[3:0], tx_ctl[7:2], tx_ctl[0]};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && head_idx == tail_idx && !head_load) |=> !mem_req);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req);
  assert_done_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[STS_LSB+STS_DD] && rs_bit));
  assert_wb_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb |-> $past(mem_we && mem_ack, 2));
  assert_qe_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_qe |-> (head_idx == tail_idx));
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !tx_ctl[CTL_EN]) |=> (state_q == S_IDLE));
endmodule

// File: tb/txr_engine_bench.sv
`timescale 1ns/1ps
module txr_engine_bench;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 12;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [ADDR_W-1:0] ring_base = BASE;
  logic [IDX_W+4:0]  ring_bytes = 17'd64;
  logic [IDX_W-1:0]  tail_idx = '0;
  logic [7:0]        tx_ctl = 8'h02;
  logic              head_load = 1'b0;
  logic [IDX_W-1:0]  head_wdata = '0;
  logic [IDX_W-1:0]  head_idx;
  logic              mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0]       mem_wdata, mem_rdata;
  logic              out_valid, out_last, ev_wb, ev_qe;
  logic [7:0]        out_data;

  txr_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_txr_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_bytes(ring_bytes),
    .tail_idx(tail_idx), .tx_ctl(tx_ctl), .head_load(head_load),
    .head_wdata(head_wdata), .head_idx(head_idx), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .ev_wb(ev_wb), .ev_qe(ev_qe));

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:4095];
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_data = '0;

  function automatic logic [7:0] pat(input logic [11:0] a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [7:0] rd_byte(input logic [11:0] a);
    return (a >= 12'h200) ? pat(a) : mem[a];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        for (int b = 0; b < 8; b++) begin
          mem_rdata[8*b +: 8] <= rd_byte(12'((mem_addr & ~32'h7) + 32'(b)));
          if (mem_we) mem[12'((mem_addr & ~32'h7) + 32'(b))] <= mem_wdata[8*b +: 8];
        end
      end
      if (host_we) mem[host_addr] <= host_data;
    end
  end

  // ---------------- output monitor ----------------
  logic [7:0] got [0:63];
  int got_n, last_n, last_pos, wb_n, qe_n, req_n;
  logic mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      got_n <= 0; last_n <= 0; last_pos <= -1; wb_n <= 0; qe_n <= 0; req_n <= 0;
    end else begin
      if (out_valid) begin
        if (got_n < 64) got[got_n] <= out_data;
        got_n <= got_n + 1;
        if (out_last) begin last_n <= last_n + 1; last_pos <= got_n; end
      end
      if (ev_wb)   wb_n  <= wb_n + 1;
      if (ev_qe)   qe_n  <= qe_n + 1;
      if (mem_req) req_n <= req_n + 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_err + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    step(1);
    mon_clr = 1'b0;
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_data = d;
    step(1);
    host_we = 1'b0;
  endtask

  task automatic wr_desc(input int idx, input logic [31:0] addr,
                         input logic [15:0] len, input logic [7:0] cmd);
    logic [11:0] d;
    d = 12'(BASE + 32'(idx * 16));
    for (int b = 0; b < 8; b++) poke(d + 12'(b), (b < 4) ? addr[8*b +: 8] : 8'h00);
    poke(d + 12'd8,  len[7:0]);
    poke(d + 12'd9,  len[15:8]);
    poke(d + 12'd10, 8'h00);
    poke(d + 12'd11, cmd);
    for (int b = 12; b < 16; b++) poke(d + 12'(b), 8'h00);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      step(1);
      if (head_idx == tail_idx && !mem_req && !out_valid) break;
    end
    step(4);
  endtask

  task automatic chk_bytes(input string tag, input int n, input int a1,
                           input int len1, input int a2);
    int mism;
    mism = 0;
    for (int i = 0; i < n; i++) begin
      if (got[i] != ((i < len1) ? pat(12'(a1 + i)) : pat(12'(a2 + i - len1)))) mism++;
    end
    check(tag, mism, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1 reset head", head_idx, 0);
    check("R1 reset mem_req", mem_req, 0);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset events", {ev_wb, ev_qe}, 0);
  endtask

  task automatic t_single();
    wr_desc(0, 32'h200, 16'd5, 8'h09);
    clear_mon();
    tail_idx = 12'd1;
    wait_idle();
    check("R3 single byte count", got_n, 5);
    chk_bytes("R3 single byte values", 5, 'h200, 5, 0);
    check("R4 single last count", last_n, 1);
    check("R4 single last position", last_pos, 4);
    check("R5 single done bit", mem[12'h10C], 8'h01);
    check("R5 single length kept", mem[12'h108], 8'h05);
    check("R5 single cmd kept", mem[12'h10B], 8'h09);
    check("R6 single wb event", wb_n, 1);
    check("R8 single qe event", qe_n, 1);
    check("R7 single head", head_idx, 1);
  endtask

  task automatic t_multi();
    wr_desc(1, 32'h203, 16'd10, 8'h00);
    wr_desc(2, 32'h305, 16'd3,  8'h01);
    clear_mon();
    tail_idx = 12'd3;
    wait_idle();
    check("R3 multi byte count", got_n, 13);
    chk_bytes("R3 multi unaligned bytes", 13, 'h203, 10, 'h305);
    check("R4 multi single last", last_n, 1);
    check("R4 multi last position", last_pos, 12);
    check("R5 multi no writeback d1", mem[12'h11C], 8'h00);
    check("R5 multi no writeback d2", mem[12'h12C], 8'h00);
    check("R5 multi no wb event", wb_n, 0);
    check("R8 multi qe once", qe_n, 1);
    check("R2 multi head", head_idx, 3);
  endtask

  task automatic t_wrap();
    wr_desc(3, 32'h3F0, 16'd9, 8'h08);
    wr_desc(0, 32'h400, 16'd2, 8'h09);
    head_load = 1'b1; head_wdata = 12'd3;
    step(1);
    head_load = 1'b0;
    clear_mon();
    tail_idx = 12'd1;
    wait_idle();
    check("R7 wrap head", head_idx, 1);
    check("R7 wrap byte count", got_n, 11);
    chk_bytes("R7 wrap bytes", 11, 'h3F0, 9, 'h400);
    check("R4 wrap last position", last_pos, 10);
    check("R5 wrap done d3", mem[12'h13C], 8'h01);
    check("R6 wrap wb events", wb_n, 2);
  endtask

  task automatic t_zero_len();
    wr_desc(1, 32'h500, 16'd0, 8'h09);
    clear_mon();
    tail_idx = 12'd2;
    wait_idle();
    check("R10 zero no bytes", got_n, 0);
    check("R10 zero no last", last_n, 0);
    check("R10 zero done bit", mem[12'h11C], 8'h01);
    check("R10 zero wb event", wb_n, 1);
    check("R10 zero head", head_idx, 2);
  endtask

  task automatic t_enable();
    tx_ctl = 8'h00;
    wr_desc(2, 32'h600, 16'd20, 8'h09);
    wr_desc(3, 32'h700, 16'd20, 8'h09);
    clear_mon();
    tail_idx = 12'd0;
    step(50);
    check("R9 disabled no request", req_n, 0);
    check("R1 disabled head held", head_idx, 2);
    tx_ctl = 8'h02;
    for (int i = 0; i < 500; i++) begin
      step(1);
      if (out_valid) break;
    end
    tx_ctl = 8'h00;
    step(200);
    check("R9 stop after current head", head_idx, 3);
    check("R9 stop after current bytes", got_n, 20);
    check("R9 stop no qe", qe_n, 0);
    tx_ctl = 8'h02;
    wait_idle();
    check("R9 resume head", head_idx, 0);
    check("R9 resume bytes", got_n, 40);
    chk_bytes("R3 resume bytes", 40, 'h600, 20, 'h700);
    check("R8 resume qe", qe_n, 1);
    check("R4 resume last count", last_n, 2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_single();
    t_multi();
    t_wrap();
    t_zero_len();
    t_enable();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule